// File: doc/BRIEF.md
# Tagged Multi-Channel Debug Word FIFO Controller

This block sits between a processor's register bus and a debug probe link. Software pushes 32-bit words into one shared transmit queue by writing to one of sixteen per-channel data addresses. The address picks the channel, and the block stores the channel number as a 4-bit tag next to the word. The probe side drains that queue through a valid/ready word port that carries the tag with the data. In the other direction, the probe side delivers tagged words into one shared receive queue. Software looks at the status register to find the channel of the next receive word, then reads the receive data register, which returns the word and removes it.

The configuration register holds two 2-bit interrupt condition selects, one for transmit and one for receive. It also reports the two queue depths, which software cannot change. A single level interrupt is raised whenever an enabled condition holds for the current queue occupancy. Queue depths and widths are parameters. The register offsets and bit fields are fixed, because software decodes them.

Top module: `dbgchan_ctrl`

## Requirements
- R1: After reset both queues are empty. Status (offset 0x10) reads 0x0000000A, configuration (offset 0x08) reads `{12'h0, 4'h0, TX_DEPTH[7:0], RX_DEPTH[7:0]}`, and `irq` is low.
- R2: A write to offset 0x20 + 8*n (n from 0 to 15) appends the write data to the transmit queue with tag n. Words leave on `tx_data`/`tx_tag` in write order. Each word is removed on a cycle where `tx_valid` and `tx_ready` are both high. `tx_valid` is high exactly when the queue holds a word.
- R3: A channel write while the transmit queue holds TX_DEPTH words is discarded, and the words already stored are unchanged.
- R4: Configuration bits 19:18 (transmit select) and 17:16 (receive select) are writable. Bits 15:8 always read TX_DEPTH and bits 7:0 always read RX_DEPTH. Written values in bits 15:0 have no effect.
- R5: Status bits 31:24 hold the transmit occupancy and bits 23:16 hold the receive occupancy. Bits 15:8 read zero.
- R6: Status bits 7:4 hold the tag of the oldest receive word, or zero when the receive queue is empty. Bit 3 is receive empty, bit 2 is receive full, bit 1 is transmit empty and bit 0 is transmit full.
- R7: Reading offset 0x18 with `bus_rd` high returns the oldest receive word and removes it at the clock edge. On an empty queue the read returns zero and changes nothing.
- R8: `rx_ready` is low while the receive queue holds RX_DEPTH words, and a word offered then is not stored.
- R9: Transmit select values: 0 = never, 1 = queue empty, 2 = queue not full, 3 = occupancy at most TX_DEPTH/4.
- R10: Receive select values: 0 = never, 1 = queue full, 2 = queue not empty, 3 = occupancy at least 3*RX_DEPTH/4.
- R11: `irq` is the OR of the two selected conditions. It follows the current occupancy in the same cycle, with no register on the path.
- R12: Offset 0x00 and every offset not listed above read zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rd | input | 1 | Register read strobe (removes a word on a receive data read) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_valid | output | 1 | Transmit word available to the probe side |
| tx_ready | input | 1 | Probe side takes the transmit word |
| tx_data | output | DATA_W | Oldest transmit word |
| tx_tag | output | TAG_W | Channel tag of the oldest transmit word |
| rx_valid | input | 1 | Probe side offers a receive word |
| rx_ready | output | 1 | Receive queue can store a word |
| rx_data | input | DATA_W | Offered receive word |
| rx_tag | input | TAG_W | Channel tag of the offered receive word |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a full queue that still gets traffic on the same edge. Examples are a channel write arriving while the transmit queue is full and the probe is stalled, or a receive word offered into a full queue, each followed by proof that the stored order survived. The stimulus holds `tx_ready` low while writing nine words across several channels, and keeps the probe side offering words after the receive queue fills. It then drains both queues and checks every word and tag against a queue-based model. The interrupt selects are stepped through all four values at the occupancy levels where each one changes.

// File: rtl/dbgchan_pkg.sv
package dbgchan_pkg;
   localparam int unsigned OFF_ACCESS = 'h00;
   localparam int unsigned OFF_CFG    = 'h08;
   localparam int unsigned OFF_STAT   = 'h10;
   localparam int unsigned OFF_RXDATA = 'h18;
   localparam int unsigned OFF_TXBASE = 'h20;
   localparam int unsigned TX_STRIDE  = 8;

   localparam int CFG_TXSEL_LSB = 18;
   localparam int CFG_RXSEL_LSB = 16;

   typedef enum logic [1:0] {
      TXI_OFF   = 2'd0,
      TXI_EMPTY = 2'd1,
      TXI_ROOM  = 2'd2,
      TXI_LOW   = 2'd3
   } tx_irq_e;

   typedef enum logic [1:0] {
      RXI_OFF   = 2'd0,
      RXI_FULL  = 2'd1,
      RXI_DATA  = 2'd2,
      RXI_HIGH  = 2'd3
   } rx_irq_e;
endpackage

// File: rtl/dbgchan_fifo.sv
module dbgchan_fifo #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 36,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             push_ok, pop_ok;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(1);
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/dbgchan_irq.sv
module dbgchan_irq
   import dbgchan_pkg::*;
#(
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8,
   localparam int TX_CW = $clog2(TX_DEPTH + 1),
   localparam int RX_CW = $clog2(RX_DEPTH + 1),
   localparam int TX_LOW_MARK  = TX_DEPTH / 4,
   localparam int RX_HIGH_MARK = (3 * RX_DEPTH) / 4
) (
   input  tx_irq_e          tx_sel,
   input  rx_irq_e          rx_sel,
   input  logic [TX_CW-1:0] tx_count,
   input  logic [RX_CW-1:0] rx_count,
   output logic             irq
);
   logic tx_hit, rx_hit;

   always_comb begin
      unique case (tx_sel)
         TXI_OFF:   tx_hit = 1'b0;
         TXI_EMPTY: tx_hit = (tx_count == '0);
         TXI_ROOM:  tx_hit = (tx_count < TX_CW'(TX_DEPTH));
         TXI_LOW:   tx_hit = (tx_count <= TX_CW'(TX_LOW_MARK));
         default:   tx_hit = 1'b0;
      endcase
   end

   always_comb begin
      unique case (rx_sel)
         RXI_OFF:   rx_hit = 1'b0;
         RXI_FULL:  rx_hit = (rx_count == RX_CW'(RX_DEPTH));
         RXI_DATA:  rx_hit = (rx_count != '0);
         RXI_HIGH:  rx_hit = (rx_count >= RX_CW'(RX_HIGH_MARK));
         default:   rx_hit = 1'b0;
      endcase
   end

   assign irq = tx_hit | rx_hit;
endmodule

// File: rtl/dbgchan_ctrl.sv
module dbgchan_ctrl
   import dbgchan_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 4,
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] tx_data,
   output logic [TAG_W-1:0]  tx_tag,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [TAG_W-1:0]  rx_tag,
   output logic              irq
);
   localparam int NCHAN = 1 << TAG_W;
   localparam int ENT_W = DATA_W + TAG_W;
   localparam int TX_CW = $clog2(TX_DEPTH + 1);
   localparam int RX_CW = $clog2(RX_DEPTH + 1);
   localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);
   localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_RXDATA = ADDR_W'(OFF_RXDATA);

   // elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32");
   end
   if (TAG_W < 1 || TAG_W > 4) begin : g_bad_tag
      $error("TAG_W must be 1..4");
   end
   if (TX_DEPTH < 4 || TX_DEPTH > 128 || (TX_DEPTH & (TX_DEPTH - 1)) != 0) begin : g_bad_txd
      $error("TX_DEPTH must be a power of two in 4..128");
   end
   if (RX_DEPTH < 4 || RX_DEPTH > 128 || (RX_DEPTH & (RX_DEPTH - 1)) != 0) begin : g_bad_rxd
      $error("RX_DEPTH must be a power of two in 4..128");
   end
   if (OFF_TXBASE + TX_STRIDE * (NCHAN - 1) >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the channel window");
   end

   // channel address decode
   logic [NCHAN-1:0] ch_hit;
   logic [TAG_W-1:0] wr_tag;
   logic             tx_push_req;

   for (genvar c = 0; c < NCHAN; c++) begin : g_chan
      assign ch_hit[c] = (bus_addr == ADDR_W'(OFF_TXBASE + TX_STRIDE * c));
   end

   always_comb begin
      wr_tag = '0;
      for (int c = 0; c < NCHAN; c++) begin
         if (ch_hit[c]) wr_tag = TAG_W'(c);
      end
   end

   assign tx_push_req = bus_wr && (|ch_hit);

   // transmit queue
   logic [ENT_W-1:0] tx_head;
   logic [TX_CW-1:0] tx_count;
   logic             tx_full, tx_empty;

   dbgchan_fifo #(.DEPTH(TX_DEPTH), .WIDTH(ENT_W)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push_req),
      .din   ({wr_tag, bus_wdata}),
      .pop   (tx_ready),
      .dout  (tx_head),
      .count (tx_count),
      .full  (tx_full),
      .empty (tx_empty)
   );

   assign tx_valid = !tx_empty;
   assign tx_data  = tx_head[DATA_W-1:0];
   assign tx_tag   = tx_head[ENT_W-1:DATA_W];

   // receive queue
   logic [ENT_W-1:0] rx_head;
   logic [RX_CW-1:0] rx_count;
   logic             rx_full, rx_empty, rx_pop;

   assign rx_pop = bus_rd && (bus_addr == A_RXDATA);

   dbgchan_fifo #(.DEPTH(RX_DEPTH), .WIDTH(ENT_W)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_valid),
      .din   ({rx_tag, rx_data}),
      .pop   (rx_pop),
      .dout  (rx_head),
      .count (rx_count),
      .full  (rx_full),
      .empty (rx_empty)
   );

   assign rx_ready = !rx_full;

   // configuration
   tx_irq_e tx_sel;
   rx_irq_e rx_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_sel <= TXI_OFF;
         rx_sel <= RXI_OFF;
      end else if (bus_wr && bus_addr == A_CFG) begin
         tx_sel <= tx_irq_e'(bus_wdata[CFG_TXSEL_LSB +: 2]);
         rx_sel <= rx_irq_e'(bus_wdata[CFG_RXSEL_LSB +: 2]);
      end
   end

   // read mux
   logic [3:0]  head_tag;
   logic [31:0] stat_word, cfg_word;

   assign head_tag  = rx_empty ? 4'h0 : 4'(rx_head[ENT_W-1:DATA_W]);
   assign stat_word = {8'(tx_count), 8'(rx_count), 8'h00, head_tag,
                       rx_empty, rx_full, tx_empty, tx_full};
   assign cfg_word  = {12'h000, tx_sel, rx_sel, 8'(TX_DEPTH), 8'(RX_DEPTH)};

   always_comb begin
      unique case (bus_addr)
         A_CFG:    bus_rdata = cfg_word;
         A_STAT:   bus_rdata = stat_word;
         A_RXDATA: bus_rdata = rx_empty ? 32'h0 : rx_head[31:0];
         default:  bus_rdata = 32'h0;
      endcase
   end

   dbgchan_irq #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_irq (
      .tx_sel   (tx_sel),
      .rx_sel   (rx_sel),
      .tx_count (tx_count),
      .rx_count (rx_count),
      .irq      (irq)
   );
endmodule

// File: rtl/dbgchan_ctrl_chk.sv
module dbgchan_ctrl_chk #(
   parameter int ADDR_W   = 8,
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8,
   localparam int TX_CW = $clog2(TX_DEPTH + 1),
   localparam int RX_CW = $clog2(RX_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic [31:0]       bus_rdata,
   input logic              tx_push_req,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              irq,
   input logic [TX_CW-1:0]  tx_cnt,
   input logic [RX_CW-1:0]  rx_cnt,
   input logic [1:0]        tx_mode,
   input logic [1:0]        rx_mode
);
   localparam logic [ADDR_W-1:0] A_RX = ADDR_W'('h18);

   // R3: occupancy never exceeds depth
   p_tx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= TX_CW'(TX_DEPTH));

   // R3: write into a full queue without a drain leaves it full
   p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt == TX_CW'(TX_DEPTH) && tx_push_req && !(tx_valid && tx_ready))
      |=> tx_cnt == TX_CW'(TX_DEPTH));

   // R2: a word is offered exactly when one is stored
   p_tx_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid == (tx_cnt != '0));

   // R7: a receive data read removes one word
   p_pop_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_RX && rx_cnt != '0 && !(rx_valid && rx_ready))
      |=> rx_cnt == $past(rx_cnt) - RX_CW'(1));

   // R7: empty read returns zero
   p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_RX && rx_cnt == '0) |-> bus_rdata == 32'h0);

   // R8: no acceptance while full
   p_rx_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == RX_CW'(RX_DEPTH)) |-> !rx_ready);

   // R11: both selects off keeps the interrupt low
   p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mode == 2'd0 && rx_mode == 2'd0) |-> !irq);
endmodule

bind dbgchan_ctrl dbgchan_ctrl_chk #(
   .ADDR_W   (ADDR_W),
   .TX_DEPTH (TX_DEPTH),
   .RX_DEPTH (RX_DEPTH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_rd      (bus_rd),
   .bus_rdata   (bus_rdata),
   .tx_push_req (tx_push_req),
   .tx_valid    (tx_valid),
   .tx_ready    (tx_ready),
   .rx_valid    (rx_valid),
   .rx_ready    (rx_ready),
   .irq         (irq),
   .tx_cnt      (tx_count),
   .rx_cnt      (rx_count),
   .tx_mode     (tx_sel),
   .rx_mode     (rx_sel)
);

// File: tb/dbgchan_ctrl_tb.sv
module dbgchan_ctrl_tb_top;
   localparam int DEP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h10;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        tx_valid, tx_ready = 1'b0;
   logic [31:0] tx_data;
   logic [3:0]  tx_tag;
   logic        rx_valid = 1'b0, rx_ready;
   logic [31:0] rx_data = '0;
   logic [3:0]  rx_tag = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit mon_en = 1'b0;

   always #2.5 clk = ~clk;

   dbgchan_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_tag(tx_tag),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_tag(rx_tag),
      .irq(irq)
   );

   // ---------------- reference model ----------------
   logic [35:0] txq[$];
   logic [35:0] rxq[$];
   int mtx = 0, mrx = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         txq.delete(); rxq.delete(); mtx = 0; mrx = 0;
      end else begin
         int  txs, rxs;
         bit  tpop, tpush, rpush, rpop;
         txs   = txq.size();
         rxs   = rxq.size();
         tpop  = tx_ready && txs > 0;
         tpush = bus_wr && bus_addr >= 8'h20 && bus_addr <= 8'h98
                 && bus_addr[2:0] == 3'b000 && txs < DEP;
         rpush = rx_valid && rxs < DEP;
         rpop  = bus_rd && bus_addr == 8'h18 && rxs > 0;
         if (bus_wr && bus_addr == 8'h08) begin
            mtx = int'(bus_wdata[19:18]);
            mrx = int'(bus_wdata[17:16]);
         end
         if (tpop) void'(txq.pop_front());
         if (tpush) txq.push_back({4'((bus_addr - 8'h20) >> 3), bus_wdata});
         if (rpop) void'(rxq.pop_front());
         if (rpush) rxq.push_back({rx_tag, rx_data});
      end
   end

   function automatic bit exp_irq();
      int t = txq.size();
      int r = rxq.size();
      bit a = (mtx == 1 && t == 0) || (mtx == 2 && t < DEP) || (mtx == 3 && t <= DEP / 4);
      bit b = (mrx == 1 && r == DEP) || (mrx == 2 && r > 0) || (mrx == 3 && r >= (3 * DEP) / 4);
      return a || b;
   endfunction

   function automatic logic [31:0] exp_read(logic [7:0] a);
      int t = txq.size();
      int r = rxq.size();
      logic [3:0] tg = (r > 0) ? rxq[0][35:32] : 4'h0;
      case (a)
         8'h08:   return (32'(mtx) << 18) | (32'(mrx) << 16) | (32'(DEP) << 8) | 32'(DEP);
         8'h10:   return {8'(t), 8'(r), 8'h00, tg, r == 0, r == DEP, t == 0, t == DEP};
         8'h18:   return (r > 0) ? rxq[0][31:0] : 32'h0;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(string req, logic [35:0] got, logic [35:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the edge
   always @(posedge clk) begin
      #1;
      if (rst_n && mon_en) begin
         chk("R11 irq", 36'(irq), 36'(exp_irq()));
         chk("R2 tx_valid", 36'(tx_valid), 36'(txq.size() > 0));
         if (txq.size() > 0) chk("R2 tx word", {tx_tag, tx_data}, txq[0]);
         chk("R8 rx_ready", 36'(rx_ready), 36'(rxq.size() < DEP));
         chk(bus_addr == 8'h10 ? "R6 status" : bus_addr == 8'h08 ? "R4 config" :
             bus_addr == 8'h18 ? "R7 rxdata" : "R12 other",
             36'(bus_rdata), 36'(exp_read(bus_addr)));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle();
      bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 8'h10;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); idle();
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk); idle();
   endtask

   task automatic peek(logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic setcfg(int t, int r);
      wr(8'h08, (32'(t) << 18) | (32'(r) << 16) | 32'h0000_FFFF);
   endtask

   task automatic drain(int n);
      @(negedge clk); tx_ready = 1'b1;
      repeat (n) @(negedge clk);
      tx_ready = 1'b0;
   endtask

   task automatic offer(logic [3:0] tg, logic [31:0] d);
      @(negedge clk); rx_valid = 1'b1; rx_tag = tg; rx_data = d;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      mon_en = 1'b1;

      // R1 reset state
      peek(8'h10, v); chk("R1 status", 36'(v), 36'h0000_000A);
      peek(8'h08, v); chk("R1 config", 36'(v), 36'h0000_0808);
      chk("R1 irq", 36'(irq), 36'h0);

      // R2 / R3: fill transmit queue with probe stalled, then overflow
      for (int i = 0; i < 8; i++) wr(8'(8'h20 + 8 * (i * 2)), 32'hA000_0000 + 32'(i));
      wr(8'h20 + 8'd72, 32'hDEAD_BEEF);
      peek(8'h10, v); chk("R3 full status", 36'(v), 36'h0800_0009);
      chk("R5 tx count", 36'(v[31:24]), 36'd8);
      chk("R2 head word", {tx_tag, tx_data}, {4'd0, 32'hA000_0000});

      // R9 with a full queue
      setcfg(2, 0); chk("R9 notfull when full", 36'(irq), 36'h0);
      setcfg(1, 0); chk("R9 empty when full", 36'(irq), 36'h0);
      setcfg(3, 0); chk("R9 low when full", 36'(irq), 36'h0);
      drain(5); #1 chk("R9 low at three", 36'(irq), 36'h0);
      drain(1); #1 chk("R9 low at two", 36'(irq), 36'h1);
      chk("R2 order and tag", {tx_tag, tx_data}, {4'd12, 32'hA000_0006});
      setcfg(1, 0); chk("R9 empty at two", 36'(irq), 36'h0);
      drain(2); #1 chk("R9 empty at zero", 36'(irq), 36'h1);
      chk("R3 dropped word absent", 36'(tx_valid), 36'h0);
      setcfg(2, 0); chk("R9 room when empty", 36'(irq), 36'h1);

      // R8 / R6 / R10: fill receive queue
      setcfg(0, 2);
      chk("R10 data idle", 36'(irq), 36'h0);
      for (int i = 0; i < 8; i++) offer(4'(15 - i), 32'h0000_00B0 + 32'(i));
      peek(8'h10, v); chk("R6 full status", 36'(v), 36'h0008_00F6);
      chk("R8 not ready", 36'(rx_ready), 36'h0);
      offer(4'h3, 32'h1234_5678);
      peek(8'h10, v); chk("R8 offer dropped", 36'(v), 36'h0008_00F6);
      setcfg(0, 1); chk("R10 full", 36'(irq), 36'h1);
      setcfg(0, 3); chk("R10 high at eight", 36'(irq), 36'h1);

      // R7 reads pop
      rd(8'h18, v); chk("R7 first word", 36'(v), 36'h0000_00B0);
      peek(8'h10, v); chk("R6 next tag", 36'(v), 36'h0007_00E2);
      rd(8'h18, v); rd(8'h18, v); chk("R7 third word", 36'(v), 36'h0000_00B2);
      chk("R10 high at five", 36'(irq), 36'h0);
      setcfg(0, 1); chk("R10 full at five", 36'(irq), 36'h0);
      for (int i = 0; i < 5; i++) rd(8'h18, v);
      chk("R7 last word", 36'(v), 36'h0000_00B7);
      rd(8'h18, v); chk("R7 empty read", 36'(v), 36'h0);
      peek(8'h10, v); chk("R7 empty unchanged", 36'(v), 36'h0000_000A);

      // R11 combination
      setcfg(1, 1); chk("R11 tx side only", 36'(irq), 36'h1);
      setcfg(0, 0); chk("R11 both off", 36'(irq), 36'h0);
      setcfg(0, 2); offer(4'h5, 32'h0000_0055);
      #1 chk("R11 rx side only", 36'(irq), 36'h1);

      // R4 read-only depth fields
      wr(8'h08, 32'h0000_1234);
      peek(8'h08, v); chk("R4 depth fields", 36'(v), 36'h0000_0808);

      // R12 unmapped and access offsets
      wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF); wr(8'h24, 32'h1);
      peek(8'h00, v); chk("R12 offset zero", 36'(v), 36'h0);
      peek(8'h04, v); chk("R12 unmapped", 36'(v), 36'h0);
      peek(8'h10, v); chk("R12 no push", 36'(v), 36'h0001_0052);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule